// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block drives the bus while a processor enters an interrupt service routine. When the core accepts an interrupt, the sequencer captures the program counter, both index registers, both accumulators, the condition code register, the stack pointer and a vector base address. It then writes the nine-byte context frame to the stack one byte per cycle, with the address counting downwards. After one idle bus cycle it reads the two-byte service vector and presents the new program counter.

A second entry serves the wait-for-interrupt instruction. A wait request stacks the same frame at once and parks the sequencer. A later interrupt accept wakes it. After a fixed recovery delay it goes straight to the vector fetch and writes nothing more. Choosing among interrupt sources and decoding instructions belong to other blocks.

States: `ST_IDLE` (waiting), `ST_PUSH` (nine stack writes), `ST_HOLD` (one dead cycle at the frame end), `ST_PARK` (frame stacked, waiting for wake), `ST_RECOVER` (wake delay), `ST_VEC_HI` and `ST_VEC_LO` (vector reads), `ST_DONE` (new PC valid).

Transitions:
- IDLE→PUSH on an accept or a wait request.
- PUSH→PUSH until the ninth byte has been written.
- PUSH→HOLD after the ninth byte on an interrupt entry.
- PUSH→PARK after the ninth byte on a wait entry.
- HOLD→VEC_HI.
- PARK→RECOVER on an accept.
- RECOVER→VEC_HI when the recovery count expires.
- VEC_HI→VEC_LO→DONE→IDLE.

Top module: `ctx_stack_seq`

## Requirements
- R1: An accept (`take_i`) in idle starts nine write cycles (`cyc_o`=1) on the following cycle. They go to addresses entry SP, SP-1, ..., SP-8, with arithmetic modulo 2^16.
- R2: The bytes are written in this order: PC[7:0], PC[15:8], IY[7:0], IY[15:8], IX[7:0], IX[15:8], B, A, CCR. All of them are captured in the accept cycle, so input changes after the accept have no effect.
- R3: After the ninth write on an interrupt entry there is exactly one cycle with `cyc_o`=0, and the address stays at SP-8.
- R4: Two read cycles follow. They read the vector base address and then base+1.
- R5: In the cycle after the second read, `pc_valid_o` pulses for one cycle. `new_pc_o` then equals {first byte read, second byte read}.
- R6: `rw_o` is 0 in every write cycle and 1 in every other cycle.
- R7: A wait request (`wait_req_i`) in idle pushes the same frame with the same timing and then parks. In the parked state `parked_o`=1, `busy_o`=0, there is no bus cycle and the address is SP-8.
- R8: An accept while parked gives exactly WAKE_CYCLES (default 4) cycles with no bus access and the address at SP-8. The two vector reads follow, with no stack writes. The vector base is sampled together with the wake accept.
- R9: `sp_o` equals the entry SP minus 9 from the cycle after the ninth write onward.
- R10: `busy_o` is 1 from the first write through the cycle where `pc_valid_o` is 1. Accepts and wait requests while busy are ignored, and a wait request while parked is ignored.
- R11: If an accept and a wait request arrive in the same idle cycle, the accept wins and the interrupt sequence runs.
- R12: During and after reset the block is idle: `cyc_o`=0, `rw_o`=1, `busy_o`=0, `parked_o`=0, `pc_valid_o`=0, `sp_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Interrupt accept pulse |
| wait_req_i | input | 1 | Wait-instruction request to pre-stack the frame |
| pc_i | input | 16 | Program counter to save |
| iy_i | input | 16 | Y index register |
| ix_i | input | 16 | X index register |
| acc_a_i | input | 8 | Accumulator A |
| acc_b_i | input | 8 | Accumulator B |
| ccr_i | input | 8 | Condition code register |
| sp_i | input | 16 | Stack pointer at entry |
| vec_base_i | input | 16 | Address of the vector high byte |
| rdata_i | input | 8 | Read data from the bus |
| addr_o | output | 16 | Bus address |
| wdata_o | output | 8 | Bus write data |
| rw_o | output | 1 | 1 = read, 0 = write |
| cyc_o | output | 1 | Bus cycle active |
| busy_o | output | 1 | Sequence in progress |
| parked_o | output | 1 | Frame stacked, waiting for wake |
| new_pc_o | output | 16 | Fetched service vector |
| pc_valid_o | output | 1 | New PC valid, one-cycle pulse |
| sp_o | output | 16 | Stack pointer after stacking |

## Verification
For an accept in idle, the first write is due one cycle later and the ninth write nine cycles later. The dead cycle comes at +10, the vector reads at +11 and +12, and the `pc_valid_o` pulse at +13. A wake from the parked state puts the reads at +5 and +6 and the pulse at +7. The bench builds the expected bus pattern as a queue of per-cycle records at the moment it drives each stimulus. At every falling edge it pops one record and compares all outputs against it. When the queue is empty it expects the idle or parked state, so ignored pulses are caught in the very cycle they would have had an effect.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

    localparam int FRAME_BYTES = 9;
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_HOLD,
        ST_PARK,
        ST_RECOVER,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_DONE
    } seq_state_e;

    typedef enum logic {
        ENTRY_IRQ,
        ENTRY_WAIT
    } entry_e;

endpackage

// File: rtl/ctx_frame_mux.sv
module ctx_frame_mux #(
    parameter int DATA_W = 8,
    parameter int LANES  = 9,
    parameter int IDX_W  = 4
) (
    input  logic [LANES*DATA_W-1:0] frame_i,
    input  logic [IDX_W-1:0]        idx_i,
    output logic [DATA_W-1:0]       byte_o
);

    logic [DATA_W-1:0] masked [LANES];

    // One AND-OR lane per frame byte, so the select stays a flat OR tree
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g] = (idx_i == IDX_W'(g)) ? frame_i[g*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        byte_o = '0;
        for (int k = 0; k < LANES; k++) begin
            byte_o = byte_o | masked[k];
        end
    end

endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    parameter int FRAME  = 9
) (
    input  logic [ADDR_W-1:0] sp_base_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] vec_base_i,
    input  logic              vec_sel_i,
    output logic [ADDR_W-1:0] push_addr_o,
    output logic [ADDR_W-1:0] frame_end_o,
    output logic [ADDR_W-1:0] sp_after_o,
    output logic [ADDR_W-1:0] vec_addr_o
);

    assign push_addr_o = sp_base_i - ADDR_W'(idx_i);
    assign frame_end_o = sp_base_i - ADDR_W'(FRAME - 1);
    assign sp_after_o  = sp_base_i - ADDR_W'(FRAME);
    assign vec_addr_o  = vec_base_i + ADDR_W'(vec_sel_i);

endmodule

// File: rtl/ctx_wake_timer.sv
module ctx_wake_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic expire_o
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == '0);

    // R8
    wake_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !start_i && !expire_o |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
    import ctx_stack_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int WAKE_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_i,
    input  logic                wait_req_i,
    input  logic [2*DATA_W-1:0] pc_i,
    input  logic [2*DATA_W-1:0] iy_i,
    input  logic [2*DATA_W-1:0] ix_i,
    input  logic [DATA_W-1:0]   acc_a_i,
    input  logic [DATA_W-1:0]   acc_b_i,
    input  logic [DATA_W-1:0]   ccr_i,
    input  logic [2*DATA_W-1:0] sp_i,
    input  logic [2*DATA_W-1:0] vec_base_i,
    input  logic [DATA_W-1:0]   rdata_i,
    output logic [2*DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0]   wdata_o,
    output logic                rw_o,
    output logic                cyc_o,
    output logic                busy_o,
    output logic                parked_o,
    output logic [2*DATA_W-1:0] new_pc_o,
    output logic                pc_valid_o,
    output logic [2*DATA_W-1:0] sp_o
);

    localparam int ADDR_W  = 2 * DATA_W;
    localparam int FRAME_W = FRAME_BYTES * DATA_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    seq_state_e          state_q, state_d;
    entry_e              entry_q;
    logic [IDX_W-1:0]    idx_q;
    logic [FRAME_W-1:0]  frame_q;
    logic [ADDR_W-1:0]   sp_base_q;
    logic [ADDR_W-1:0]   vec_q;
    logic [DATA_W-1:0]   vec_hi_q;
    logic [ADDR_W-1:0]   new_pc_q;
    logic [ADDR_W-1:0]   sp_q;

    logic [DATA_W-1:0]   push_byte;
    logic [ADDR_W-1:0]   push_addr, frame_end, sp_after, vec_addr;
    logic                wake_expire;
    logic                idle_accept, park_wake;

    assign idle_accept = (state_q == ST_IDLE) && (take_i || wait_req_i);
    assign park_wake   = (state_q == ST_PARK) && take_i;

    ctx_frame_mux #(
        .DATA_W (DATA_W),
        .LANES  (FRAME_BYTES),
        .IDX_W  (IDX_W)
    ) u_frame_mux (
        .frame_i (frame_q),
        .idx_i   (idx_q),
        .byte_o  (push_byte)
    );

    ctx_addr_gen #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .FRAME  (FRAME_BYTES)
    ) u_addr_gen (
        .sp_base_i   (sp_base_q),
        .idx_i       (idx_q),
        .vec_base_i  (vec_q),
        .vec_sel_i   (state_q == ST_VEC_LO),
        .push_addr_o (push_addr),
        .frame_end_o (frame_end),
        .sp_after_o  (sp_after),
        .vec_addr_o  (vec_addr)
    );

    ctx_wake_timer #(
        .CYCLES (WAKE_CYCLES)
    ) u_wake_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (park_wake),
        .run_i    (state_q == ST_RECOVER),
        .expire_o (wake_expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take_i || wait_req_i) state_d = ST_PUSH;
            ST_PUSH:    if (idx_q == LAST_IDX)
                            state_d = (entry_q == ENTRY_WAIT) ? ST_PARK : ST_HOLD;
            ST_HOLD:    state_d = ST_VEC_HI;
            ST_PARK:    if (take_i) state_d = ST_RECOVER;
            ST_RECOVER: if (wake_expire) state_d = ST_VEC_HI;
            ST_VEC_HI:  state_d = ST_VEC_LO;
            ST_VEC_LO:  state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Captured context and fetched vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q   <= ENTRY_IRQ;
            idx_q     <= '0;
            frame_q   <= '0;
            sp_base_q <= '0;
            vec_q     <= '0;
            vec_hi_q  <= '0;
            new_pc_q  <= '0;
            sp_q      <= '0;
        end else begin
            if (idle_accept) begin
                entry_q   <= take_i ? ENTRY_IRQ : ENTRY_WAIT;
                idx_q     <= '0;
                frame_q   <= {ccr_i, acc_a_i, acc_b_i, ix_i, iy_i, pc_i};
                sp_base_q <= sp_i;
                vec_q     <= vec_base_i;
            end
            if (park_wake) begin
                vec_q <= vec_base_i;
            end
            if (state_q == ST_PUSH) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == LAST_IDX) sp_q <= sp_after;
            end
            if (state_q == ST_VEC_HI) vec_hi_q <= rdata_i;
            if (state_q == ST_VEC_LO) new_pc_q <= {vec_hi_q, rdata_i};
        end
    end

    // Outputs
    always_comb begin
        addr_o     = frame_end;
        wdata_o    = '0;
        rw_o       = 1'b1;
        cyc_o      = 1'b0;
        busy_o     = 1'b1;
        parked_o   = 1'b0;
        pc_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy_o = 1'b0;
            ST_PUSH: begin
                addr_o  = push_addr;
                wdata_o = push_byte;
                rw_o    = 1'b0;
                cyc_o   = 1'b1;
            end
            ST_HOLD:    ;
            ST_PARK: begin
                busy_o   = 1'b0;
                parked_o = 1'b1;
            end
            ST_RECOVER: ;
            ST_VEC_HI, ST_VEC_LO: begin
                addr_o = vec_addr;
                cyc_o  = 1'b1;
            end
            ST_DONE:    pc_valid_o = 1'b1;
            default:    busy_o = 1'b0;
        endcase
    end

    assign new_pc_o = new_pc_q;
    assign sp_o     = sp_q;

    // Assertion support: length of the last recovery window
    logic [$clog2(WAKE_CYCLES + 2)-1:0] rec_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rec_len_q <= '0;
        else if (state_q == ST_PARK)   rec_len_q <= '0;
        else if (state_q == ST_RECOVER) rec_len_q <= rec_len_q + 1'b1;
    end

    // R1
    push_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_o && !rw_o && $past(cyc_o && !rw_o) |-> addr_o == $past(addr_o) - 1'b1);

    // R3
    frame_end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cyc_o && !rw_o) && !(cyc_o && !rw_o) |-> !cyc_o && addr_o == $past(addr_o));

    // R4
    vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_o && rw_o && $past(cyc_o && rw_o) |-> addr_o == $past(addr_o) + 1'b1);

    // R5
    new_pc_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid_o |-> new_pc_o == {$past(rdata_i, 2), $past(rdata_i, 1)});

    // R7
    busy_park_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, parked_o}));

    // R8
    wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_VEC_HI && $past(state_q) == ST_RECOVER |-> rec_len_q == WAKE_CYCLES);

    // R9
    sp_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cyc_o && !rw_o) && !(cyc_o && !rw_o) |-> sp_o == $past(addr_o) - 1'b1);

    // R10
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && (take_i || wait_req_i) |=> sp_base_q == $past(sp_base_q));

endmodule

// File: tb/test_ctx_stack_seq.sv
module test_ctx_stack_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_i = 1'b0, wait_req_i = 1'b0;
    logic [15:0] pc_i = '0, iy_i = '0, ix_i = '0, sp_i = '0, vec_base_i = '0;
    logic [7:0]  acc_a_i = '0, acc_b_i = '0, ccr_i = '0;
    logic [7:0]  rdata_i;
    logic [15:0] addr_o, new_pc_o, sp_o;
    logic [7:0]  wdata_o;
    logic        rw_o, cyc_o, busy_o, parked_o, pc_valid_o;

    localparam int WAKE = 4;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    assign rdata_i = mem_byte(addr_o);

    ctx_stack_seq i_ctx_stack_seq (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .wait_req_i(wait_req_i),
        .pc_i(pc_i), .iy_i(iy_i), .ix_i(ix_i), .acc_a_i(acc_a_i),
        .acc_b_i(acc_b_i), .ccr_i(ccr_i), .sp_i(sp_i), .vec_base_i(vec_base_i),
        .rdata_i(rdata_i), .addr_o(addr_o), .wdata_o(wdata_o), .rw_o(rw_o),
        .cyc_o(cyc_o), .busy_o(busy_o), .parked_o(parked_o),
        .new_pc_o(new_pc_o), .pc_valid_o(pc_valid_o), .sp_o(sp_o)
    );

    typedef struct {
        logic        cyc, rw, chk_addr, chk_data, busy, parked, pcv;
        logic [15:0] addr, npc, sp;
        logic [7:0]  wdata;
        string       tag;
    } rec_t;

    rec_t        exp_q[$];
    int          total = 0, fails = 0;
    bit          done = 0;
    logic [15:0] m_sp = '0;
    logic        m_parked = 1'b0;

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic rec_t idle_rec();
        rec_t r;
        r.cyc = 0; r.rw = 1; r.chk_addr = 0; r.chk_data = 0; r.busy = 0;
        r.parked = m_parked; r.pcv = 0; r.addr = '0; r.npc = '0; r.sp = m_sp;
        r.wdata = '0; r.tag = "R10";
        return r;
    endfunction

    task automatic tick();
        rec_t r;
        @(negedge clk);
        if (exp_q.size() > 0) r = exp_q.pop_front();
        else                  r = idle_rec();
        check(cyc_o === r.cyc, r.tag, "cyc_o", cyc_o, r.cyc);
        check(rw_o === r.rw, "R6", "rw_o", rw_o, r.rw);
        if (r.chk_addr) check(addr_o === r.addr, r.tag, "addr_o", addr_o, r.addr);
        if (r.chk_data) check(wdata_o === r.wdata, "R2", "wdata_o", wdata_o, r.wdata);
        check(busy_o === r.busy, "R10", "busy_o", busy_o, r.busy);
        check(parked_o === r.parked, "R7", "parked_o", parked_o, r.parked);
        check(pc_valid_o === r.pcv, "R5", "pc_valid_o", pc_valid_o, r.pcv);
        if (r.pcv) check(new_pc_o === r.npc, "R5", "new_pc_o", new_pc_o, r.npc);
        check(sp_o === r.sp, "R9", "sp_o", sp_o, r.sp);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic add_push(logic [15:0] pc, iy, ix, logic [7:0] a, b, ccr, logic [15:0] sp);
        logic [7:0] fb [9];
        rec_t r;
        fb = '{pc[7:0], pc[15:8], iy[7:0], iy[15:8], ix[7:0], ix[15:8], b, a, ccr};
        for (int i = 0; i < 9; i++) begin
            r = idle_rec();
            r.cyc = 1; r.rw = 0; r.chk_addr = 1; r.addr = sp - 16'(i);
            r.chk_data = 1; r.wdata = fb[i]; r.busy = 1; r.parked = 0;
            r.sp = m_sp; r.tag = "R1";
            exp_q.push_back(r);
        end
    endtask

    task automatic add_vec(logic [15:0] vec, logic [15:0] sp_new, int gap, string gtag);
        rec_t r;
        for (int i = 0; i < gap; i++) begin
            r = idle_rec();
            r.chk_addr = 1; r.addr = sp_new + 16'd1; r.busy = 1; r.parked = 0;
            r.sp = sp_new; r.tag = gtag;
            exp_q.push_back(r);
        end
        for (int i = 0; i < 2; i++) begin
            r = idle_rec();
            r.cyc = 1; r.chk_addr = 1; r.addr = vec + 16'(i); r.busy = 1;
            r.parked = 0; r.sp = sp_new; r.tag = "R4";
            exp_q.push_back(r);
        end
        r = idle_rec();
        r.busy = 1; r.parked = 0; r.pcv = 1; r.sp = sp_new; r.tag = "R5";
        r.npc = {mem_byte(vec), mem_byte(vec + 16'd1)};
        exp_q.push_back(r);
    endtask

    task automatic accept(bit tk, bit wt, logic [15:0] pc, iy, ix,
                          logic [7:0] a, b, ccr, logic [15:0] sp, vec);
        logic [15:0] sp_new;
        pc_i = pc; iy_i = iy; ix_i = ix; acc_a_i = a; acc_b_i = b; ccr_i = ccr;
        sp_i = sp; vec_base_i = vec; take_i = tk; wait_req_i = wt;
        sp_new = sp - 16'd9;
        add_push(pc, iy, ix, a, b, ccr, sp);
        if (tk) begin
            add_vec(vec, sp_new, 1, "R3");      // R3 dead cycle, R11 when both asserted
        end else begin
            m_parked = 1'b1;                    // R7
        end
        m_sp = sp_new;
        tick();
        take_i = 0; wait_req_i = 0;
    endtask

    task automatic wake(logic [15:0] vec);
        vec_base_i = vec; take_i = 1;
        add_vec(vec, m_sp, WAKE, "R8");
        m_parked = 1'b0;
        tick();
        take_i = 0;
    endtask

    initial begin
        // R12: reset state
        run(3);
        rst_n = 1'b1;
        run(2);

        // R1 R2 R3 R4 R5 R6 R9: plain interrupt entry
        accept(1, 0, 16'hC123, 16'h4567, 16'h89AB, 8'h11, 8'h22, 8'hD4, 16'h01FF, 16'hFFF2);
        run(15);

        // R2 R10: inputs change and pulses arrive while busy
        accept(1, 0, 16'h0F1E, 16'h2D3C, 16'h4B5A, 8'h69, 8'h78, 8'h87, 16'h8000, 16'hFFF6);
        run(3);
        pc_i = 16'hDEAD; ix_i = 16'hBEEF; acc_a_i = 8'h00; sp_i = 16'h1234;
        vec_base_i = 16'h0100; take_i = 1; wait_req_i = 1;
        tick();
        take_i = 0; wait_req_i = 0;
        run(8);
        take_i = 1;                              // R10: accept during DONE cycle
        tick();
        take_i = 0;
        run(3);

        // R1 R9: stack address wraps below zero
        accept(1, 0, 16'h7777, 16'h0001, 16'hFFFE, 8'hA0, 8'h0B, 8'hC0, 16'h0004, 16'hFFFE);
        run(14);

        // R11: accept and wait request together
        accept(1, 1, 16'h5555, 16'hAAAA, 16'h3C3C, 8'h01, 8'h02, 8'h03, 16'h0300, 16'hFFF0);
        run(14);

        // R7 R8: wait entry, park, ignored wait request, then wake
        accept(0, 1, 16'h9ABC, 16'hDEF0, 16'h1357, 8'h24, 8'h68, 8'hC5, 16'h0450, 16'h0000);
        run(12);
        wait_req_i = 1; sp_i = 16'h2222;         // R10: ignored while parked
        tick();
        wait_req_i = 0;
        run(3);
        wake(16'hFFF4);
        run(10);

        // R7 R8: park and wake immediately after the frame
        accept(0, 1, 16'h0102, 16'h0304, 16'h0506, 8'h07, 8'h08, 8'h09, 16'h00FF, 16'h0000);
        run(9);
        wake(16'hFFE0);
        run(10);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule